// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Programmable Level Flags

This block is a first-in first-out buffer for nine-bit words whose write side and read side each run on their own clock. The two clocks may be completely unrelated or may be the same net. The memory sits inside the block. Its depth is a power-of-two parameter. Each port has two enables, and both must be in their active state before a word moves. The read side holds the word it delivers in an output register. That register drives the data bus only while the output enable is high and leaves the bus floating otherwise.

Four level indications come out of the block. Empty and a programmable almost-empty level are computed on the read clock. Full and a programmable almost-full level are computed on the write clock. The two thresholds are loaded over the data input. When the first write enable is active and the second is held low, each write-clock edge stores the data bus into a threshold, alternating between the two, and no word enters the queue. Pointers pass between the clock domains as Gray code through two-stage synchronisers, so a change made on one side reaches the flags of the other side a few clocks later.

Top module: `fifo9_dc`

## Requirements
- R1: A word is stored on a rising wrClk edge only when wrEn1N is 0 and wrEn2Ld is 1. It is stored on every such edge while both stay in that state. Any other combination with wrEn1N at 1 stores nothing and loads nothing.
- R2: A word is removed on a rising rdClk edge only when rdEn1N is 0 and rdEn2 is 1. The removed word appears in the output register right after that edge. Other enable combinations leave the queue and the output register unchanged.
- R3: Words leave in the order they entered. This holds with independent clocks, with wrClk and rdClk tied together, and with writes and reads running at the same time.
- R4: While outEn is 1, qOut shows the output register. While outEn is 0, qOut is high-impedance.
- R5: fullFlag rises right after the write edge that brings the stored count to DEPTH. A write request while fullFlag is 1 stores nothing.
- R6: emptyFlag rises right after the read edge that removes the last word. A read request while emptyFlag is 1 moves no pointer and leaves qOut unchanged.
- R7: almostEmpty is 1 whenever the read-side count is less than or equal to the almost-empty offset.
- R8: almostFull is 1whenever the write-side count is at least DEPTH minus the almost-full offset.
- R9: While wrEn1N is 0 and wrEn2Ld is 0, each wrClk edge copies dIn into an offset register and stores no word. The first such edge after reset loads the almost-empty offset, the next loads the almost-full offset, and the loads keep alternating in that order.
- R10: While rstN is 0, and after it returns to 1, emptyFlag and almostEmpty are 1, fullFlag and almostFull are 0, the output register is 0, both offsets are 7 and the next offset load targets the almost-empty offset.
- R11: A write clears emptyFlag by the second rising rdClk edge after the write edge. A read clears fullFlag by the second rising wrClk edge after the read edge. Neither flag clears at the edge of the other domain itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrEn1N | input | 1 | First write enable, active low |
| wrEn2Ld | input | 1 | Second write enable, high to write, low to load an offset |
| dIn | input | 9 | Write data and offset value |
| rdClk | input | 1 | Read-side clock, may be tied to wrClk |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2 | input | 1 | Second read enable, active high |
| outEn | input | 1 | Drives qOut when high, floats it when low |
| qOut | output | 9 | Read data from the output register, tri-state |
| rstN | input | 1 | Asynchronous reset, active low |
| emptyFlag | output | 1 | Queue holds no word (read domain) |
| almostEmpty | output | 1 | Count at or below the almost-empty offset (read domain) |
| almostFull | output | 1 | Count within the almost-full offset of DEPTH (write domain) |
| fullFlag | output | 1 | Queue holds DEPTH words (write domain) |

## Verification
The hardest state to reach from the ports is a full queue while both clocks keep running, with writes being refused and reads draining at the same moment. The stimulus starts a continuous writer and holds the reader back for several hundred nanoseconds. The writer therefore runs into Full and has to retry, and the reader then drains the queue concurrently. This is done once with the 20 ns and 27 ns clocks out of phase and once with the clocks tied. The threshold flags are stepped one word at a time in both directions and allowed to settle at each step, under both the default offsets and offsets loaded by three alternating load edges.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

  // Strobes handed from the control section to the storage section.
  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } fifoStrobes_t;

  // Which offset register the next load edge writes.
  typedef enum logic {
    SEL_EMPTY_OFFS = 1'b0,
    SEL_FULL_OFFS  = 1'b1
  } offsSel_e;

endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 9,
  parameter int OFFS_DEFAULT = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  logic                       wrEn1N,
  input  logic                       wrEn2Ld,
  input  logic                       rdEn1N,
  input  logic                       rdEn2,
  input  logic [DATA_W-1:0]          dIn,
  output fifoStrobes_t               strb,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       emptyFlag,
  output logic                       almostEmpty,
  output logic                       almostFull,
  output logic                       fullFlag
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = ((PW > DATA_W) ? PW : DATA_W) + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wrReq, ldReq, wrDo;
  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdGraySyncW, rdBinW, wrCount;
  logic [DATA_W-1:0] aeOffs, afOffs;
  offsSel_e      ldSel;

  assign wrReq     = !wrEn1N && wrEn2Ld;
  assign ldReq     = !wrEn1N && !wrEn2Ld;
  assign wrDo      = wrReq && !fullFlag;
  assign wrBinNext = wrBin + PW'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrDo) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOffs <= DATA_W'(OFFS_DEFAULT);
      afOffs <= DATA_W'(OFFS_DEFAULT);
      ldSel  <= SEL_EMPTY_OFFS;
    end else if (ldReq) begin
      if (ldSel == SEL_EMPTY_OFFS) begin
        aeOffs <= dIn;
        ldSel  <= SEL_FULL_OFFS;
      end else begin
        afOffs <= dIn;
        ldSel  <= SEL_EMPTY_OFFS;
      end
    end
  end

  // ---------------- read domain ----------------
  logic          rdReq, rdDo;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] wrGraySyncR, wrBinR, rdCount;

  assign rdReq     = !rdEn1N && rdEn2;
  assign rdDo      = rdReq && !emptyFlag;
  assign rdBinNext = rdBin + PW'(1);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdDo) begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  // ---------------- crossings ----------------
  fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) rdToWr_i (
    .clk (wrClk),
    .rstN(rstN),
    .din (rdGray),
    .dout(rdGraySyncW)
  );

  fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) wrToRd_i (
    .clk (rdClk),
    .rstN(rstN),
    .din (wrGray),
    .dout(wrGraySyncR)
  );

  // ---------------- flags ----------------
  assign rdBinW      = fromGray(rdGraySyncW);
  assign wrCount     = wrBin - rdBinW;
  assign fullFlag    = (wrCount == PW'(DEPTH));
  assign almostFull  = (CW'(wrCount) + CW'(afOffs)) >= CW'(DEPTH);

  assign wrBinR      = fromGray(wrGraySyncR);
  assign rdCount     = wrBinR - rdBin;
  assign emptyFlag   = (rdCount == '0);
  assign almostEmpty = CW'(rdCount) <= CW'(aeOffs);

  // ---------------- to datapath ----------------
  assign strb.wrStrobe = wrDo;
  assign strb.rdStrobe = rdDo;
  assign wrAddr        = wrBin[AW-1:0];
  assign rdAddr        = rdBin[AW-1:0];

endmodule

// File: rtl/fifo9_datapath.sv
module fifo9_datapath
  import fifo9_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 9
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  fifoStrobes_t             strb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        dIn,
  output logic [DATA_W-1:0]        qReg
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrStrobe) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              qReg <= '0;
    else if (strb.rdStrobe) qReg <= mem[rdAddr];
  end

endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc
  import fifo9_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 9,
  parameter int OFFS_DEFAULT = 7
) (
  input  logic              wrClk,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic [DATA_W-1:0] dIn,
  input  logic              rdClk,
  input  logic              rdEn1N,
  input  logic              rdEn2,
  input  logic              outEn,
  output logic [DATA_W-1:0] qOut,
  input  logic              rstN,
  output logic              emptyFlag,
  output logic              almostEmpty,
  output logic              almostFull,
  output logic              fullFlag
);

  localparam int AW = $clog2(DEPTH);

  fifoStrobes_t      strb;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic [DATA_W-1:0] qReg;

  fifo9_ctrl #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .OFFS_DEFAULT(OFFS_DEFAULT), .SYNC_STAGES(2)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2(rdEn2),
    .dIn(dIn), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyFlag(emptyFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .fullFlag(fullFlag)
  );

  fifo9_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dIn(dIn), .qReg(qReg)
  );

  assign qOut = outEn ? qReg : 'z;

endmodule

// File: rtl/fifo9_checker.sv
module fifo9_checker
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                     wrClk,
  input logic                     rdClk,
  input logic                     rstN,
  input logic                     wrEn1N,
  input logic                     wrEn2Ld,
  input logic                     rdEn1N,
  input logic                     rdEn2,
  input logic                     emptyFlag,
  input logic                     almostEmpty,
  input logic                     almostFull,
  input logic                     fullFlag,
  input fifoStrobes_t             strb,
  input logic [$clog2(DEPTH)-1:0] wrAddr,
  input logic [$clog2(DEPTH)-1:0] rdAddr
);

  localparam int AW = $clog2(DEPTH);

  a_r1_write_advances: assert property (@(posedge wrClk) disable iff (!rstN)
    strb.wrStrobe |=> wrAddr == AW'($past(wrAddr) + 1'b1));

  a_r2_read_advances: assert property (@(posedge rdClk) disable iff (!rstN)
    strb.rdStrobe |=> rdAddr == AW'($past(rdAddr) + 1'b1));

  a_r5_full_blocks_write: assert property (@(posedge wrClk) disable iff (!rstN)
    (fullFlag && !wrEn1N && wrEn2Ld) |=> $stable(wrAddr));

  a_r6_empty_blocks_read: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyFlag && !rdEn1N && rdEn2) |=> $stable(rdAddr));

  a_r7_empty_within_ae: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyFlag |-> almostEmpty);

  a_r8_full_within_af: assert property (@(posedge wrClk) disable iff (!rstN)
    fullFlag |-> almostFull);

  a_r9_load_no_write: assert property (@(posedge wrClk) disable iff (!rstN)
    (!wrEn1N && !wrEn2Ld) |-> !strb.wrStrobe);

endmodule

bind fifo9_dc fifo9_checker #(.DEPTH(DEPTH)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2(rdEn2),
  .emptyFlag(emptyFlag), .almostEmpty(almostEmpty),
  .almostFull(almostFull), .fullFlag(fullFlag),
  .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/fifo9_dc_tb.sv
`timescale 1ns/100ps
module fifo9_dc_tb_top;

  localparam int DEPTH = 16;

  logic wrClkR = 1'b0;
  logic rdClkR = 1'b0;
  logic tieClks = 1'b0;
  wire  wrClk, rdClk;
  logic rstN = 1'b0;
  logic wrEn1N = 1'b1, wrEn2Ld = 1'b1, rdEn1N = 1'b1, rdEn2 = 1'b0, outEn = 1'b1;
  logic [8:0] dIn = '0;
  wire  [8:0] qOut;
  logic benchDrv = 1'b0;
  logic emptyFlag, almostEmpty, almostFull, fullFlag;

  int vectors = 0;
  int miscompares = 0;
  logic [8:0] model[$];
  logic [8:0] lastQ;

  assign wrClk = wrClkR;
  assign rdClk = tieClks ? wrClkR : rdClkR;
  assign qOut  = benchDrv ? 9'h0A5 : 'z;

  initial forever #10 wrClkR = ~wrClkR;
  initial begin #0.3; forever #13.5 rdClkR = ~rdClkR; end

  fifo9_dc #(.DEPTH(DEPTH), .DATA_W(9), .OFFS_DEFAULT(7)) dut_i (
    .wrClk(wrClk), .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .dIn(dIn),
    .rdClk(rdClk), .rdEn1N(rdEn1N), .rdEn2(rdEn2), .outEn(outEn),
    .qOut(qOut), .rstN(rstN), .emptyFlag(emptyFlag), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .fullFlag(fullFlag)
  );

  function automatic logic [8:0] val(input int i);
    return 9'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit tied);
    rstN = 1'b0;
    wrEn1N = 1'b1; wrEn2Ld = 1'b1; rdEn1N = 1'b1; rdEn2 = 1'b0; outEn = 1'b1;
    benchDrv = 1'b0; dIn = '0;
    tieClks = tied;
    model.delete();
    lastQ = '0;
    repeat (3) @(posedge rdClk);
    repeat (3) @(posedge wrClk);
    @(negedge wrClkR);
    rstN = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    #2;
  endtask

  task automatic writeWord(input logic [8:0] d);
    bit acc;
    @(posedge wrClk); #2;
    wrEn1N = 1'b0; wrEn2Ld = 1'b1; dIn = d;
    acc = !fullFlag;
    @(posedge wrClk); #2;
    wrEn1N = 1'b1;
    if (acc) model.push_back(d);
  endtask

  task automatic readWord(input string req);
    bit avail;
    logic [8:0] exp;
    @(posedge rdClk); #2;
    avail = !emptyFlag;
    rdEn1N = 1'b0; rdEn2 = 1'b1;
    @(posedge rdClk); #2;
    rdEn1N = 1'b1; rdEn2 = 1'b0;
    if (avail) begin
      exp = model.pop_front();
      check(qOut == exp, req, qOut, exp);
      lastQ = exp;
    end else begin
      check(qOut == lastQ, "R6 read while empty holds qOut", qOut, lastQ);
    end
  endtask

  // R10 reset state
  task automatic t_reset();
    doReset(1'b0);
    #2;
    check(emptyFlag == 1'b1, "R10 empty after reset", emptyFlag, 1);
    check(almostEmpty == 1'b1, "R10 almostEmpty after reset", almostEmpty, 1);
    check(fullFlag == 1'b0, "R10 full after reset", fullFlag, 0);
    check(almostFull == 1'b0, "R10 almostFull after reset", almostFull, 0);
    check(qOut == 9'h000, "R10 output register after reset", qOut, 0);
  endtask

  // R7 R8 flag levels stepped up and down
  task automatic t_levels(input int aeThr, input int afThr);
    for (int k = 1; k <= DEPTH; k++) begin
      writeWord(val(k));
      settle();
      check(almostEmpty == (k <= aeThr), "R7 almostEmpty filling", almostEmpty, int'(k <= aeThr));
      check(almostFull == (k >= DEPTH - afThr), "R8 almostFull filling", almostFull, int'(k >= DEPTH - afThr));
    end
    for (int k = DEPTH - 1; k >= 0; k--) begin
      readWord("R3 order while draining");
      settle();
      check(almostEmpty == (k <= aeThr), "R7 almostEmpty draining", almostEmpty, int'(k <= aeThr));
      check(almostFull == (k >= DEPTH - afThr), "R8 almostFull draining", almostFull, int'(k >= DEPTH - afThr));
    end
  endtask

  // R9 alternating offset loads, then levels against loaded offsets
  task automatic t_offsets();
    doReset(1'b0);
    @(posedge wrClk); #2;
    wrEn1N = 1'b0; wrEn2Ld = 1'b0; dIn = 9'd5;
    @(posedge wrClk); #2; dIn = 9'd3;
    @(posedge wrClk); #2; dIn = 9'd2;
    @(posedge wrClk); #2;
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
    settle();
    check(emptyFlag == 1'b1, "R9 load edges store no word", emptyFlag, 1);
    t_levels(2, 3);
  endtask

  // R10 offsets back at 7 after reset
  task automatic t_default_levels();
    doReset(1'b0);
    t_levels(7, 7);
  endtask

  // R5 R6 fill past full, drain past empty
  task automatic t_fill_drain();
    doReset(1'b0);
    for (int i = 0; i < DEPTH - 1; i++) writeWord(val(i + 100));
    check(fullFlag == 1'b0, "R5 not full at DEPTH-1", fullFlag, 0);
    writeWord(val(200));
    check(fullFlag == 1'b1, "R5 full right after last write", fullFlag, 1);
    for (int i = 0; i < 3; i++) writeWord(9'h1EE);
    settle();
    for (int i = 0; i < DEPTH; i++) readWord("R3 order after fill");
    check(emptyFlag == 1'b1, "R6 empty right after last read", emptyFlag, 1);
    readWord("R6 extra read");
    readWord("R6 extra read");
    settle();
    check(emptyFlag == 1'b1, "R5 writes while full not stored", emptyFlag, 1);
    writeWord(9'h1AB);
    settle();
    readWord("R6 read pointer unmoved by reads while empty");
  endtask

  // R1 R2 inactive enable combinations
  task automatic t_enables();
    doReset(1'b0);
    @(posedge wrClk); #2;
    dIn = 9'h000;
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
    repeat (3) @(posedge wrClk);
    #2; wrEn2Ld = 1'b0;
    repeat (3) @(posedge wrClk);
    #2; wrEn2Ld = 1'b1;
    settle();
    check(emptyFlag == 1'b1, "R1 no store with wrEn1N high", emptyFlag, 1);
    for (int i = 0; i < 7; i++) writeWord(val(i + 300));
    settle();
    check(almostEmpty == 1'b1, "R1 no offset load with wrEn1N high", almostEmpty, 1);
    @(posedge rdClk); #2;
    rdEn1N = 1'b1; rdEn2 = 1'b1;
    repeat (3) @(posedge rdClk);
    #2; rdEn1N = 1'b0; rdEn2 = 1'b0;
    repeat (3) @(posedge rdClk);
    #2; rdEn1N = 1'b1;
    check(qOut == 9'h000, "R2 no read with one enable inactive", qOut, 0);
    for (int i = 0; i < 7; i++) readWord("R2 words kept after inactive reads");
    check(emptyFlag == 1'b1, "R2 all seven words remained", emptyFlag, 1);
  endtask

  // R4 output enable
  task automatic t_outen();
    doReset(1'b0);
    writeWord(9'h155);
    settle();
    readWord("R3 single word");
    outEn = 1'b0;
    #1 benchDrv = 1'b1;
    #2;
    check(qOut == 9'h0A5, "R4 qOut released when outEn low", qOut, 9'h0A5);
    benchDrv = 1'b0;
    #1 outEn = 1'b1;
    #2;
    check(qOut == 9'h155, "R4 qOut driven when outEn high", qOut, 9'h155);
  endtask

  // R11 crossing latency
  task automatic t_latency();
    doReset(1'b0);
    writeWord(9'h0C3);
    check(emptyFlag == 1'b1, "R11 empty not cleared at write edge", emptyFlag, 1);
    repeat (2) @(posedge rdClk);
    #2;
    check(emptyFlag == 1'b0, "R11 empty cleared by second rdClk edge", emptyFlag, 0);
    for (int i = 0; i < DEPTH - 1; i++) writeWord(val(i + 400));
    settle();
    readWord("R3 first word after latency fill");
    check(fullFlag == 1'b1, "R11 full not cleared at read edge", fullFlag, 1);
    repeat (2) @(posedge wrClk);
    #2;
    check(fullFlag == 1'b0, "R11 full cleared by second wrClk edge", fullFlag, 0);
  endtask

  // R3 R5 concurrent streaming, independent or tied clocks
  task automatic t_stream(input bit tied, input int n);
    bit sawFull = 1'b0;
    doReset(tied);
    fork
      begin
        int i = 0;
        bit acc;
        @(posedge wrClk); #2;
        wrEn1N = 1'b0; wrEn2Ld = 1'b1;
        while (i < n) begin
          dIn = val(i + 500);
          acc = !fullFlag;
          @(posedge wrClk); #2;
          if (acc) begin model.push_back(val(i + 500)); i++; end
          else sawFull = 1'b1;
        end
        wrEn1N = 1'b1;
      end
      begin
        int got = 0;
        bit avail;
        logic [8:0] exp;
        #500;
        @(posedge rdClk); #2;
        rdEn1N = 1'b0; rdEn2 = 1'b1;
        while (got < n) begin
          avail = !emptyFlag;
          @(posedge rdClk); #2;
          if (avail) begin
            exp = model.pop_front();
            check(qOut == exp, tied ? "R3 order tied clocks" : "R3 order independent clocks", qOut, exp);
            got++;
          end
        end
        rdEn1N = 1'b1; rdEn2 = 1'b0;
      end
    join
    check(sawFull == 1'b1, "R5 writer stalled on full during stream", sawFull, 1);
    settle();
    check(emptyFlag == 1'b1, "R3 stream fully drained", emptyFlag, 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #3_000_000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_offsets();
    t_default_levels();
    t_fill_drain();
    t_enables();
    t_outen();
    t_latency();
    t_stream(1'b0, 40);
    t_stream(1'b1, 30);
    summary();
    $finish;
  end

endmodule